// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and turns a set of interrupt source flags into one request. Each source has its own flag, enable bit, 3-bit priority and 2-bit sub-priority. Every cycle the controller picks one winner among the sources that are flagged, enabled and have a nonzero priority. It reports the winner's vector number and priority. It raises a request to the core when that priority is above the level the core is already running at.

The handler address that goes with the request is computed, not stored in a table. In multi-vector mode the address is a programmable base plus the vector number times a power-of-two spacing. In single-vector mode every vector uses the base address. The lowest-numbered sources can also be set by external pins. Each pin passes through a two-flop synchronizer and then an edge detector whose direction is chosen per pin. Software programs the block, and can set or clear any flag, through a simple write port and a combinational read port.

Top module: `pic_top`

## Requirements
- R1: A source can win only when its flag is set, its enable bit is 1 and its priority is nonzero. A disabled source, or one with priority 0, is never reported, even while its flag stays set.
- R2: Among eligible sources, the one with the highest priority wins.
- R3: Among eligible sources of equal priority, the one with the higher sub-priority wins.
- R4: When priority and sub-priority are both equal, the lowest vector number wins.
- R5: `irq_o` is 1 only when a winner exists and its priority is strictly greater than `cpu_prio_i`.
- R6: In multi-vector mode, `handler_o` = base + vector × (8 << spacing_sel). The mode and spacing are set in global word 0: bit 0 = multi, bits [3:1] = spacing_sel.
- R7: In single-vector mode (global word 0, bit 0 = 0), `handler_o` equals the base address for every vector. The base address is held in global word 1.
- R8: External pin k sets the flag of source k on one edge only. Polarity bit k is bit 8+k of global word 0: 1 selects the rising edge, 0 the falling edge. After reset every polarity bit is 1. The opposite edge has no effect.
- R9: Flags are sticky. A write to flag word i (region 1) with data bit 0 = 1 sets flag i, and with bit 0 = 0 clears it. A hardware set in the same cycle as a software clear leaves the flag set.
- R10: `win_valid_o`, `win_vec_o` and `win_prio_o` report the current winner one cycle after the state changes. With no winner, all status outputs, `irq_o` and `handler_o` are 0.
- R11: After reset all flags, enables, priorities, base and mode are 0, so no request or winner is reported.
- R12: Reads return the stored state. The address is {region[1:0], index[7:0]}. Region 0 holds source config: prio [2:0], sub [4:3], enable [5], and a read-only flag at [8]. Region 1 holds the flag at [0]. Region 2 holds the global words 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Hardware flag set strobes, one per source |
| ext_i | input | N_EXT | Asynchronous external interrupt pins, mapped to sources 0..N_EXT-1 |
| cpu_prio_i | input | 3 | Priority level the core is currently running at |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Write address {region, index} |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 10 | Read address {region, index} |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| handler_o | output | 32 | Handler entry address for the winner |
| win_valid_o | output | 1 | A winner exists |
| win_vec_o | output | VEC_W | Winning vector number |
| win_prio_o | output | 3 | Winning priority |

## Verification
The assertions check on every cycle the rules that hold at any instant. The reported winner is always flagged, enabled and of nonzero priority. The request never goes out at or below the core's level. The idle status is all zero. The single-vector address equals the base. A flag falls only where software cleared it. A hardware set always lands, and an edge strobe never lasts two cycles. Only the bench scenarios can show the ordering results: which of several competing sources wins by priority, by sub-priority and by vector number, the multi-vector address arithmetic, rejection of the wrong pin edge, and the read-back layout.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int REG_AW = 10;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 3;
  localparam int SUB_W  = 2;
  localparam int KEY_W  = PRIO_W + SUB_W;

  typedef enum logic [1:0] {
    RGN_SRC  = 2'd0,
    RGN_FLAG = 2'd1,
    RGN_GLB  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [SUB_W-1:0]  sub;
    logic              en;
  } src_cfg_t;

  function automatic rgn_e addr_rgn(input logic [REG_AW-1:0] a);
    return rgn_e'(a[REG_AW-1 -: 2]);
  endfunction

  function automatic logic [7:0] addr_idx(input logic [REG_AW-1:0] a);
    return a[7:0];
  endfunction
endpackage

// File: rtl/pic_ext_edge.sv
module pic_ext_edge #(
  parameter int N_EXT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] pol_i,
  output logic [N_EXT-1:0] edge_o
);
  logic [N_EXT-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // pol=1 rising, pol=0 falling
  assign edge_o = (pol_i & s2_q & ~s3_q) | (~pol_i & ~s2_q & s3_q);

  assert_edge_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pol_i) |-> ((edge_o & $past(edge_o)) == '0));
endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SRC-1:0]           set_i,
  input  logic                       wr_en_i,
  input  logic [REG_AW-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [N_SRC-1:0]           flag_o,
  output logic [N_SRC-1:0]           en_o,
  output logic [N_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [N_SRC-1:0][SUB_W-1:0]  sub_o
);
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] clr_mask;
  src_cfg_t         cfg_q [N_SRC];

  rgn_e       wr_rgn;
  logic [7:0] wr_idx;
  assign wr_rgn = addr_rgn(wr_addr_i);
  assign wr_idx = addr_idx(wr_addr_i);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic flag_hit, cfg_hit;
    assign flag_hit    = wr_en_i && (wr_rgn == RGN_FLAG) && (wr_idx == 8'(i));
    assign cfg_hit     = wr_en_i && (wr_rgn == RGN_SRC)  && (wr_idx == 8'(i));
    assign clr_mask[i] = flag_hit & ~wr_data_i[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        cfg_q[i]  <= '0;
      end else begin
        // hardware set dominates a same-cycle clear
        flag_q[i] <= set_i[i] | (flag_hit ? wr_data_i[0] : flag_q[i]);
        if (cfg_hit) begin
          cfg_q[i].prio <= wr_data_i[2:0];
          cfg_q[i].sub  <= wr_data_i[4:3];
          cfg_q[i].en   <= wr_data_i[5];
        end
      end
    end

    assign en_o[i]   = cfg_q[i].en;
    assign prio_o[i] = cfg_q[i].prio;
    assign sub_o[i]  = cfg_q[i].sub;
  end

  assign flag_o = flag_q;

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~$past(clr_mask) & $past(flag_q) & ~flag_q) == '0));
  assert_hw_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(set_i) & ~flag_q) == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             flag_i,
  input  logic [N_SRC-1:0]             en_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0][SUB_W-1:0]  sub_i,
  output logic                         valid_o,
  output logic [VEC_W-1:0]             vec_o,
  output logic [PRIO_W-1:0]            prio_o
);
  logic [KEY_W-1:0] best_key;

  // strict compare keeps the lowest index on a full tie
  always_comb begin
    best_key = '0;
    vec_o    = '0;
    valid_o  = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (flag_i[i] && en_i[i] && (prio_i[i] != '0) &&
          ({prio_i[i], sub_i[i]} > best_key)) begin
        best_key = {prio_i[i], sub_i[i]};
        vec_o    = VEC_W'(i);
        valid_o  = 1'b1;
      end
    end
    prio_o = best_key[KEY_W-1 -: PRIO_W];
  end

  assert_win_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_i[vec_o] && en_i[vec_o] && (prio_i[vec_o] == prio_o) && (prio_o != '0)));
  assert_win_beats_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (vec_o != '0) && flag_i[0] && en_i[0]) |->
      ({prio_i[0], sub_i[0]} < {prio_o, sub_i[vec_o]}));
endmodule

// File: rtl/pic_vec_addr.sv
module pic_vec_addr
  import pic_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic              multi_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [3:0]        shamt;
  logic [DATA_W-1:0] offs;

  assign shamt  = {1'b0, sel_i} + 4'd3;
  assign offs   = DATA_W'(vec_i) << shamt;
  assign addr_o = multi_i ? (base_i + offs) : base_i;
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_EXT = 5,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic [2:0]        cpu_prio_i,
  input  logic              wr_en_i,
  input  logic [9:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [9:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o,
  output logic [31:0]       handler_o,
  output logic              win_valid_o,
  output logic [VEC_W-1:0]  win_vec_o,
  output logic [2:0]        win_prio_o
);
  logic              multi_q;
  logic [2:0]        sel_q;
  logic [N_EXT-1:0]  pol_q;
  logic [DATA_W-1:0] base_q;

  rgn_e       wr_rgn, rd_rgn;
  logic [7:0] wr_idx, rd_idx;
  assign wr_rgn = addr_rgn(wr_addr_i);
  assign wr_idx = addr_idx(wr_addr_i);
  assign rd_rgn = addr_rgn(rd_addr_i);
  assign rd_idx = addr_idx(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      multi_q <= 1'b0;
      sel_q   <= '0;
      pol_q   <= '1;
      base_q  <= '0;
    end else if (wr_en_i && wr_rgn == RGN_GLB) begin
      if (wr_idx == 8'd0) begin
        multi_q <= wr_data_i[0];
        sel_q   <= wr_data_i[3:1];
        pol_q   <= wr_data_i[8 +: N_EXT];
      end else if (wr_idx == 8'd1) begin
        base_q  <= wr_data_i;
      end
    end
  end

  logic [N_EXT-1:0] ext_edge;
  pic_ext_edge #(.N_EXT(N_EXT)) u_ext (
    .clk_i, .rst_ni, .pin_i(ext_i), .pol_i(pol_q), .edge_o(ext_edge)
  );

  logic [N_SRC-1:0] set_vec;
  always_comb begin
    set_vec = src_i;
    set_vec[N_EXT-1:0] = src_i[N_EXT-1:0] | ext_edge;
  end

  logic [N_SRC-1:0]             flag, en;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_SRC-1:0][SUB_W-1:0]  sub;

  pic_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i, .rst_ni, .set_i(set_vec),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .flag_o(flag), .en_o(en), .prio_o(prio), .sub_o(sub)
  );

  logic              arb_valid;
  logic [VEC_W-1:0]  arb_vec;
  logic [PRIO_W-1:0] arb_prio;

  pic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk_i, .rst_ni, .flag_i(flag), .en_i(en), .prio_i(prio), .sub_i(sub),
    .valid_o(arb_valid), .vec_o(arb_vec), .prio_o(arb_prio)
  );

  logic [DATA_W-1:0] hdl;
  pic_vec_addr #(.VEC_W(VEC_W)) u_addr (
    .multi_i(multi_q), .sel_i(sel_q), .base_i(base_q), .vec_i(arb_vec), .addr_o(hdl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_vec_o   <= '0;
      win_prio_o  <= '0;
      irq_o       <= 1'b0;
      handler_o   <= '0;
    end else begin
      win_valid_o <= arb_valid;
      win_vec_o   <= arb_vec;
      win_prio_o  <= arb_prio;
      irq_o       <= arb_valid && (arb_prio > cpu_prio_i);
      handler_o   <= arb_valid ? hdl : '0;
    end
  end

  logic             rd_in_range;
  logic [VEC_W-1:0] rd_sel;
  assign rd_in_range = int'(rd_idx) < N_SRC;
  assign rd_sel      = rd_idx[VEC_W-1:0];

  always_comb begin
    rd_data_o = '0;
    unique case (rd_rgn)
      RGN_SRC:  if (rd_in_range)
                  rd_data_o = {23'd0, flag[rd_sel], 2'd0, en[rd_sel], sub[rd_sel], prio[rd_sel]};
      RGN_FLAG: if (rd_in_range) rd_data_o = {31'd0, flag[rd_sel]};
      RGN_GLB:  if (rd_idx == 8'd0) begin
                  rd_data_o[0]          = multi_q;
                  rd_data_o[3:1]        = sel_q;
                  rd_data_o[8 +: N_EXT] = pol_q;
                end else if (rd_idx == 8'd1) rd_data_o = base_q;
      default:  rd_data_o = '0;
    endcase
  end

  assert_req_above_cpu_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_valid_o && (win_prio_o > $past(cpu_prio_i))));
  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_valid_o |-> (!irq_o && win_prio_o == '0 && win_vec_o == '0 && handler_o == '0));
  assert_single_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !$past(multi_q)) |-> (handler_o == $past(base_q)));
endmodule

// File: tb/sim_pic_top.sv
module sim_pic_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 32;
  localparam int N_EXT = 5;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_SRC-1:0]  src_i = '0;
  logic [N_EXT-1:0]  ext_i = '0;
  logic [2:0]        cpu_prio_i = '0;
  logic              wr_en_i = 1'b0;
  logic [9:0]        wr_addr_i = '0;
  logic [31:0]       wr_data_i = '0;
  logic [9:0]        rd_addr_i = '0;
  logic [31:0]       rd_data_o;
  logic              irq_o;
  logic [31:0]       handler_o;
  logic              win_valid_o;
  logic [4:0]        win_vec_o;
  logic [2:0]        win_prio_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_top #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u0 (
    .clk_i(clk), .rst_ni, .src_i, .ext_i, .cpu_prio_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .irq_o, .handler_o, .win_valid_o, .win_vec_o, .win_prio_o
  );

  typedef struct {
    logic        valid;
    int          vec;
    int          prio;
    logic        irq;
    logic [31:0] hdl;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares outputs against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(win_valid_o == e.valid, e.req, "valid", win_valid_o, e.valid);
      chk(int'(win_vec_o) == e.vec, e.req, "vec", win_vec_o, e.vec);
      chk(int'(win_prio_o) == e.prio, e.req, "prio", win_prio_o, e.prio);
      chk(irq_o == e.irq, e.req, "irq", irq_o, e.irq);
      chk(handler_o == e.hdl, e.req, "handler", handler_o, e.hdl);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] rgn, input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = {rgn, 8'(idx)}; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] mv_addr(input int vec, input int sel);
    return BASE + 32'(vec * (8 << sel));
  endfunction

  task automatic expect_out(input logic v, input int vec, input int p, input logic irq,
                            input logic [31:0] h, input string req);
    exp_t e;
    tick(3);
    e.valid = v; e.vec = vec; e.prio = p; e.irq = irq; e.hdl = h; e.req = req;
    q.push_back(e);
    tick(1);
  endtask

  task automatic rd_chk(input logic [1:0] rgn, input int idx, input logic [31:0] exp,
                        input string req);
    rd_addr_i = {rgn, 8'(idx)};
    #2;
    chk(rd_data_o == exp, req, "rdata", rd_data_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    // R11 reset state
    expect_out(0, 0, 0, 0, 32'h0, "R11");
    rd_chk(2'd0, 3, 32'h0, "R11");
    rd_chk(2'd2, 0, 32'h1F00, "R12");

    wr(2'd2, 1, BASE);
    wr(2'd0, 5, 32'h2B);              // prio3 sub1 en
    wr(2'd1, 5, 32'h1);               // software set R9
    expect_out(1, 5, 3, 1, BASE, "R7");

    wr(2'd2, 0, 32'h1F05);            // multi, sel=2
    expect_out(1, 5, 3, 1, mv_addr(5, 2), "R6");

    wr(2'd0, 9, 32'h25);              // prio5
    @(posedge clk); #1; src_i[9] = 1'b1;
    @(posedge clk); #1; src_i[9] = 1'b0;
    expect_out(1, 9, 5, 1, mv_addr(9, 2), "R2");

    wr(2'd0, 12, 32'h3D);             // prio5 sub3
    wr(2'd1, 12, 32'h1);
    expect_out(1, 12, 5, 1, mv_addr(12, 2), "R3");

    wr(2'd0, 7, 32'h3D);
    wr(2'd1, 7, 32'h1);
    expect_out(1, 7, 5, 1, mv_addr(7, 2), "R4");

    cpu_prio_i = 3'd5;
    expect_out(1, 7, 5, 0, mv_addr(7, 2), "R5");
    cpu_prio_i = 3'd4;
    expect_out(1, 7, 5, 1, mv_addr(7, 2), "R5");
    cpu_prio_i = 3'd0;

    wr(2'd0, 7, 32'h1D);              // disable
    expect_out(1, 12, 5, 1, mv_addr(12, 2), "R1");
    wr(2'd0, 12, 32'h38);             // prio 0
    expect_out(1, 9, 5, 1, mv_addr(9, 2), "R1");
    rd_chk(2'd1, 7, 32'h1, "R9");
    rd_chk(2'd0, 12, 32'h138, "R12");

    wr(2'd1, 9, 32'h0);
    expect_out(1, 5, 3, 1, mv_addr(5, 2), "R9");

    // hardware set and software clear in the same cycle
    @(posedge clk); #1;
    src_i[5] = 1'b1; wr_en_i = 1'b1; wr_addr_i = {2'd1, 8'd5}; wr_data_i = 32'h0;
    @(posedge clk); #1;
    src_i[5] = 1'b0; wr_en_i = 1'b0;
    expect_out(1, 5, 3, 1, mv_addr(5, 2), "R9");

    wr(2'd1, 5, 32'h0);
    wr(2'd1, 7, 32'h0);
    wr(2'd1, 12, 32'h0);
    expect_out(0, 0, 0, 0, 32'h0, "R10");

    // external pin 2, rising edge
    wr(2'd0, 2, 32'h27);
    ext_i[2] = 1'b1;
    tick(3);
    expect_out(1, 2, 7, 1, mv_addr(2, 2), "R8");
    wr(2'd1, 2, 32'h0);
    ext_i[2] = 1'b0;
    tick(3);
    expect_out(0, 0, 0, 0, 32'h0, "R8");

    // switch pin 2 to falling edge
    wr(2'd2, 0, 32'h1B05);
    ext_i[2] = 1'b1;
    tick(3);
    expect_out(0, 0, 0, 0, 32'h0, "R8");
    ext_i[2] = 1'b0;
    tick(3);
    expect_out(1, 2, 7, 1, mv_addr(2, 2), "R8");
    rd_chk(2'd1, 2, 32'h1, "R12");
    rd_chk(2'd2, 0, 32'h1B05, "R12");

    wr(2'd2, 0, 32'h1B04);            // back to single vector
    expect_out(1, 2, 7, 1, BASE, "R7");

    tick(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule